// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation converter. Software reaches it over a small synchronous byte bus. It holds an enable bit, a start/busy bit, a justification bit and a completion flag. The block paces its work on a single-cycle TAD strobe. It puts a 10-bit trial code on `trial_code` and reads the external comparator's verdict on `cmp_in`. The converted value is held as a high/low byte pair, and the justification bit chooses how that pair is packed.

A conversion starts in one of two ways: software writes the start bit, or a hardware trigger input fires. The trigger also sends a one-cycle pulse that clears an external timer. If software clears the start bit mid-conversion, the conversion is abandoned and the old result stays. The block then waits two TAD periods before it returns to acquiring on its own. When the device sleeps, the outcome depends on the clock source. With the dedicated RC clock, the start is deferred by one instruction cycle and the conversion runs to the end. It then either wakes the device or shuts itself down. With any other clock, sleep kills the conversion and shuts the block down. In every shutdown case the enable bit still reads 1.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, the control, result-high and result-low registers all read 0, `adif` is 0 and `acq` is 0.
- R2: Register map: control at address 0 (bit 0 enable, bit 1 start/busy, bit 2 justification, bit 3 flag, other bits read 0), result-high at address 1, result-low at address 2. With enable at 0, the start bit never sets. A write that sets enable and start together leaves start at 0.
- R3: A conversion takes 11 TAD strobes. The first strobe drives trial code 0x200. Each later strobe resolves one bit, from the MSB down. A bit is kept when `cmp_in` is 1, which means the analog input is at or above the trial code. The result therefore equals the input value.
- R4: On the edge that completes a conversion, the start bit clears, the flag sets and the result updates, all together.
- R5: With justification 0, high = result[9:2] and low = {result[1:0], 6'b0}. With justification 1, high = {6'b0, result[9:8]} and low = result[7:0]. The bit is applied when the pair is read.
- R6: Writing the control register with enable 1 and start 0 during a conversion stops it. The start bit clears, the result pair is unchanged and the flag does not set.
- R7: After such an abort, `acq` stays 0 and start writes are ignored until two TAD strobes have passed. After that, `acq` returns to 1 by itself.
- R8: Writing control bit 3 as 0 clears the flag. Writing it as 1 leaves the flag unchanged.
- R9: A pulse on `evt_trig` while the block is enabled and idle sets the start bit and begins a conversion. Every trigger pulse is echoed on `tmr_clr` one cycle later.
- R10: In sleep with the RC clock selected, a started conversion resolves no trial bit until an `instr_stb` pulse arrives.
- R11: In sleep with the RC clock selected and `irq_en` at 1, completion drives a one-cycle pulse on `wake`.
- R12: In sleep with the RC clock selected and `irq_en` at 0, completion produces no wake and shuts the block down. Enable still reads 1, `acq` reads 0, and start writes are ignored until enable is written to 0.
- R13: In sleep with another clock selected, a conversion in progress is abandoned with the result unchanged and no flag. The block shuts down the same way, and enable still reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| tad_stb | input | 1 | One-cycle TAD period strobe |
| trial_code | output | 10 | Trial code to the external DAC |
| cmp_in | input | 1 | Comparator decision (1: input at or above trial) |
| clk_is_rc | input | 1 | Dedicated RC conversion clock selected |
| sleep_req | input | 1 | Device is in sleep |
| irq_en | input | 1 | Conversion interrupt enabled |
| instr_stb | input | 1 | Instruction-cycle strobe |
| evt_trig | input | 1 | Hardware start trigger |
| tmr_clr | output | 1 | Pulse that clears the external timer |
| adif | output | 1 | Conversion-complete flag |
| acq | output | 1 | Block enabled, idle and acquiring |
| wake | output | 1 | Wake pulse at completion during sleep |

## Verification
A corrupted successive-approximation register shows up at once on `trial_code`, and one TAD later it becomes a wrong result byte. A stuck or miscounted step counter makes `adif` rise earlier or later than the eleventh strobe. A control state that fails to leave holdoff keeps `acq` low past two strobes. A state that leaves holdoff too early lets a start write through, so the start bit reads 1 on the very next register read. A missing shutdown flag after sleep is visible on the next cycle as `acq` at 1.

// File: rtl/adc_seq_pkg.sv
// Shared encodings for the ADC sequencer: register addresses, control bit
// positions and the control-state type.
package adc_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // enabled and acquiring, or disabled
        ST_WAIT = 2'd1,   // start deferred to next instruction cycle
        ST_CONV = 2'd2,   // successive approximation running
        ST_HOLD = 2'd3    // post-abort holdoff
    } seq_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_RESH = 2'd1;
    localparam logic [1:0] ADDR_RESL = 2'd2;

    localparam int CB_ON   = 0;
    localparam int CB_GO   = 1;
    localparam int CB_FMT  = 2;
    localparam int CB_FLAG = 3;
endpackage

// File: rtl/adc_sar_core.sv
// Successive-approximation register and step counter.
// Assumes: `clear` and `run` are never high together; `run` is high only while
// the owner is in its converting state. One setup strobe, then one bit per strobe.
module adc_sar_core #(
    parameter int RES_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                run,
    input  logic                tad_stb,
    input  logic                cmp_in,
    output logic [RES_BITS-1:0] code,
    output logic [RES_BITS-1:0] final_code,
    output logic                done
);
    localparam int STEP_W = $clog2(RES_BITS + 1);

    logic [STEP_W-1:0]   step_q;
    logic [RES_BITS-1:0] sar_q;
    logic [RES_BITS-1:0] sar_nx;

    // Next trial code: set MSB on setup, else resolve current bit and set the next.
    always_comb begin
        int bit_idx;
        sar_nx  = sar_q;
        bit_idx = RES_BITS - int'(step_q);
        if (step_q == '0) begin
            sar_nx[RES_BITS-1] = 1'b1;
        end else begin
            for (int i = 0; i < RES_BITS; i++) begin
                if (i == bit_idx)     sar_nx[i] = cmp_in;
                if (i == bit_idx - 1) sar_nx[i] = 1'b1;
            end
        end
    end

    assign done       = run && tad_stb && (step_q == STEP_W'(RES_BITS));
    assign final_code = sar_nx;
    assign code       = sar_q;

    // Advance the approximation on each TAD strobe while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            sar_q  <= '0;
        end else if (clear) begin
            step_q <= '0;
            sar_q  <= '0;
        end else if (run && tad_stb) begin
            sar_q  <= sar_nx;
            step_q <= step_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc_result_fmt.sv
// Packs a result into a high/low byte pair, left or right justified,
// zero-filling the unused positions. Assumes RES_BITS <= 2*BYTE_W.
module adc_result_fmt #(
    parameter int RES_BITS = 10,
    parameter int BYTE_W   = 8
) (
    input  logic [RES_BITS-1:0] result,
    input  logic                right_just,
    output logic [BYTE_W-1:0]   hi_byte,
    output logic [BYTE_W-1:0]   lo_byte
);
    localparam int WORD_W = 2 * BYTE_W;
    localparam int PAD_W  = WORD_W - RES_BITS;

    logic [WORD_W-1:0] word;

    // Choose the justification of the 16-bit view.
    always_comb begin
        if (right_just) word = {{PAD_W{1'b0}}, result};
        else            word = {result, {PAD_W{1'b0}}};
    end

    assign hi_byte = word[WORD_W-1:BYTE_W];
    assign lo_byte = word[BYTE_W-1:0];
endmodule

// File: rtl/adc_seq_ctrl.sv
// ADC conversion control sequencer: register bank, start/abort/sleep control
// and result storage around the SAR core. Assumes tad_stb, instr_stb and
// evt_trig are single-cycle pulses; the analog side is external.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS  = 10,
    parameter int BYTE_W    = 8,
    parameter int ADDR_W    = 2,
    parameter int HOLD_TADS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [BYTE_W-1:0]   rd_data,
    input  logic                tad_stb,
    output logic [RES_BITS-1:0] trial_code,
    input  logic                cmp_in,
    input  logic                clk_is_rc,
    input  logic                sleep_req,
    input  logic                irq_en,
    input  logic                instr_stb,
    input  logic                evt_trig,
    output logic                tmr_clr,
    output logic                adif,
    output logic                acq,
    output logic                wake
);
    localparam int HCNT_W = $clog2(HOLD_TADS + 1);

    seq_state_e          state_q;
    logic                on_q, go_q, fmt_q, flag_q, halted_q, wake_q, tmr_clr_q;
    logic [RES_BITS-1:0] res_q;
    logic [HCNT_W-1:0]   hold_cnt_q;

    logic                ctrl_wr, wr_on, turn_off, busy, can_start;
    logic                start, sw_abort, slp_abort, core_done, conv_done;
    logic [RES_BITS-1:0] final_code;
    logic [BYTE_W-1:0]   res_hi, res_lo;
    wire                 unused_wr_bits = &{1'b0, wr_data[BYTE_W-1:4]};

    // Decode of writes and of start/abort/complete events.
    always_comb begin
        ctrl_wr   = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
        wr_on     = wr_data[CB_ON];
        turn_off  = ctrl_wr && !wr_on;
        busy      = (state_q == ST_WAIT) || (state_q == ST_CONV);
        can_start = on_q && !halted_q && (state_q == ST_IDLE) && !turn_off;
        start     = can_start && ((ctrl_wr && wr_data[CB_GO]) || evt_trig);
        sw_abort  = ctrl_wr && wr_on && !wr_data[CB_GO] && busy;
        slp_abort = busy && sleep_req && !clk_is_rc && !turn_off;
        conv_done = core_done && !turn_off && !sw_abort && !slp_abort;
    end

    adc_sar_core #(.RES_BITS(RES_BITS)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .run       (state_q == ST_CONV),
        .tad_stb   (tad_stb),
        .cmp_in    (cmp_in),
        .code      (trial_code),
        .final_code(final_code),
        .done      (core_done)
    );

    adc_result_fmt #(.RES_BITS(RES_BITS), .BYTE_W(BYTE_W)) u_fmt (
        .result    (res_q),
        .right_just(fmt_q),
        .hi_byte   (res_hi),
        .lo_byte   (res_lo)
    );

    // Control state machine with post-abort holdoff counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            hold_cnt_q <= '0;
        end else if (turn_off) begin
            state_q    <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) state_q <= (sleep_req && clk_is_rc) ? ST_WAIT : ST_CONV;
                ST_WAIT, ST_CONV: begin
                    if (slp_abort) state_q <= ST_IDLE;
                    else if (sw_abort) begin
                        state_q    <= ST_HOLD;
                        hold_cnt_q <= '0;
                    end else if (state_q == ST_WAIT && instr_stb) state_q <= ST_CONV;
                    else if (conv_done) state_q <= ST_IDLE;
                end
                ST_HOLD: if (tad_stb) begin
                    hold_cnt_q <= hold_cnt_q + 1'b1;
                    if (hold_cnt_q == HCNT_W'(HOLD_TADS - 1)) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Register bank: enable, start, justification, flag, result, shutdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q <= 1'b0; go_q <= 1'b0; fmt_q <= 1'b0; flag_q <= 1'b0;
            halted_q <= 1'b0; res_q <= '0;
        end else begin
            if (ctrl_wr) begin
                on_q  <= wr_on;
                fmt_q <= wr_data[CB_FMT];
            end
            if (turn_off) go_q <= 1'b0;
            else if (start) go_q <= 1'b1;
            else if (sw_abort || slp_abort || conv_done) go_q <= 1'b0;
            if (conv_done) flag_q <= 1'b1;
            else if (ctrl_wr && !wr_data[CB_FLAG]) flag_q <= 1'b0;
            if (conv_done) res_q <= final_code;
            if (turn_off) halted_q <= 1'b0;
            else if (slp_abort) halted_q <= 1'b1;
            else if (conv_done && sleep_req && clk_is_rc && !irq_en) halted_q <= 1'b1;
        end
    end

    // Single-cycle output pulses: wake and timer clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_q    <= 1'b0;
            tmr_clr_q <= 1'b0;
        end else begin
            wake_q    <= conv_done && sleep_req && clk_is_rc && irq_en;
            tmr_clr_q <= evt_trig;
        end
    end

    // Read multiplexer.
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_W'(ADDR_CTRL): begin
                rd_data[CB_ON]   = on_q;
                rd_data[CB_GO]   = go_q;
                rd_data[CB_FMT]  = fmt_q;
                rd_data[CB_FLAG] = flag_q;
            end
            ADDR_W'(ADDR_RESH): rd_data = res_hi;
            ADDR_W'(ADDR_RESL): rd_data = res_lo;
            default:            rd_data = '0;
        endcase
    end

    assign adif    = flag_q;
    assign acq     = on_q && !halted_q && (state_q == ST_IDLE);
    assign wake    = wake_q;
    assign tmr_clr = tmr_clr_q;
endmodule

// File: rtl/adc_seq_chk.sv
// Assertion checker for adc_seq_ctrl, attached by bind below.
module adc_seq_chk #(
    parameter int RES_BITS = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                on_q,
    input logic                go_q,
    input logic                flag_q,
    input logic [RES_BITS-1:0] res_q,
    input logic [RES_BITS-1:0] final_code,
    input logic                conv_done,
    input logic                sw_abort,
    input logic                ctrl_wr,
    input logic                wr_flag_bit,
    input logic                acq,
    input logic                evt_trig,
    input logic                tmr_clr,
    input logic                sleep_req,
    input logic                clk_is_rc
);
    a_r2_off_blocks_go: assert property (@(posedge clk) disable iff (!rst_n)
        !on_q |=> !go_q);

    a_r4_done_together: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> (!go_q && flag_q && res_q == $past(final_code)));

    a_r6_abort_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        sw_abort |=> (!go_q && res_q == $past(res_q)));

    a_r7_hold_no_acq: assert property (@(posedge clk) disable iff (!rst_n)
        sw_abort |=> !acq);

    a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wr_flag_bit && !conv_done) |=> !flag_q);

    a_r9_trig_echo: assert property (@(posedge clk) disable iff (!rst_n)
        evt_trig |=> tmr_clr);

    a_r13_sleep_kill: assert property (@(posedge clk) disable iff (!rst_n)
        (go_q && sleep_req && !clk_is_rc) |=> (!go_q && res_q == $past(res_q)));
endmodule

bind adc_seq_ctrl adc_seq_chk #(.RES_BITS(RES_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .on_q       (on_q),
    .go_q       (go_q),
    .flag_q     (flag_q),
    .res_q      (res_q),
    .final_code (final_code),
    .conv_done  (conv_done),
    .sw_abort   (sw_abort),
    .ctrl_wr    (ctrl_wr),
    .wr_flag_bit(wr_data[adc_seq_pkg::CB_FLAG]),
    .acq        (acq),
    .evt_trig   (evt_trig),
    .tmr_clr    (tmr_clr),
    .sleep_req  (sleep_req),
    .clk_is_rc  (clk_is_rc)
);

// File: tb/tb_adc_seq_ctrl.sv
// Scoreboard bench: start tasks queue expected byte pairs, a monitor pops
// and compares them whenever the completion flag rises.
module tb_adc_seq_ctrl;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0, rd_sel = '0, mon_addr = '0, rd_addr;
    logic [7:0] wr_data = '0, rd_data;
    logic       tad_auto = 1'b0, tad_man = 1'b0, tad_stb, auto_en = 1'b0;
    logic [9:0] trial_code, vin = '0;
    logic       cmp_in, clk_is_rc = 1'b0, sleep_req = 1'b0, irq_en = 1'b0;
    logic       instr_stb = 1'b0, evt_trig = 1'b0;
    logic       tmr_clr, adif, acq, wake, mon_active = 1'b0, adif_prev = 1'b0;
    logic       wake_seen;
    int         checks = 0, fails = 0, tcnt = 0;
    logic [15:0] exp_q[$];
    logic [7:0] d, h0, l0;

    always #2.5 clk = ~clk;

    assign tad_stb = tad_auto | tad_man;
    assign cmp_in  = (trial_code <= vin);
    assign rd_addr = mon_active ? mon_addr : rd_sel;

    adc_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .tad_stb(tad_stb), .trial_code(trial_code),
        .cmp_in(cmp_in), .clk_is_rc(clk_is_rc), .sleep_req(sleep_req), .irq_en(irq_en),
        .instr_stb(instr_stb), .evt_trig(evt_trig), .tmr_clr(tmr_clr), .adif(adif),
        .acq(acq), .wake(wake)
    );

    // Free-running TAD strobe, one cycle in four, when enabled.
    always @(negedge clk) begin
        tcnt++;
        tad_auto = auto_en && (tcnt % 4 == 0);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        rd_sel = a; #0.5; v = rd_data;
    endtask

    task automatic push_exp(input logic [9:0] v, input logic fmt);
        if (fmt) exp_q.push_back({6'b0, v[9:8], v[7:0]});
        else     exp_q.push_back({v[9:2], v[1:0], 6'b0});
    endtask

    // Queue the expected pair and issue a software start.
    task automatic start_conv(input logic [9:0] v, input logic fmt, input logic expect_done);
        vin = v;
        if (expect_done) push_exp(v, fmt);
        wr(2'd0, {5'b0, fmt, 2'b11});
    endtask

    task automatic pulse_tad();
        @(negedge clk); tad_man = 1'b1;
        @(negedge clk); tad_man = 1'b0;
    endtask

    task automatic wait_done(input string req);
        wake_seen = 1'b0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (wake) wake_seen = 1'b1;
            if (adif) break;
        end
        chk(req, adif, 1'b1);
        @(negedge clk);
    endtask

    // Monitor: on each rising flag, read the result pair and compare to the queue head.
    always @(negedge clk) begin
        if (rst_n && adif && !adif_prev) begin
            logic [7:0] mh, ml;
            logic [15:0] e;
            mon_active = 1'b1; mon_addr = 2'd1; #0.2 mh = rd_data;
            mon_addr = 2'd2; #0.2 ml = rd_data; mon_active = 1'b0;
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R4 unexpected completion actual=%0h expected=none", {mh, ml});
            end else begin
                e = exp_q.pop_front();
                chk("R3 result pair", {mh, ml}, e);
            end
        end
        adif_prev = adif;
    end

    initial begin
        #600000;
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd(2'd0, d); chk("R1 ctrl", d, 8'h00);
        rd(2'd1, d); chk("R1 hi", d, 8'h00);
        rd(2'd2, d); chk("R1 lo", d, 8'h00);
        chk("R1 adif", adif, 1'b0);
        chk("R1 acq", acq, 1'b0);
        // R2: start while off is ignored, even in the enabling write
        wr(2'd0, 8'h02); rd(2'd0, d); chk("R2 off go", d, 8'h00);
        wr(2'd0, 8'h03); rd(2'd0, d); chk("R2 same write", d, 8'h01);
        chk("R2 acq", acq, 1'b1);
        // R3: manual strobes, 11 per conversion, MSB trial first
        start_conv(10'h2A5, 1'b0, 1'b1);
        pulse_tad(); chk("R3 first trial", trial_code, 10'h200);
        repeat (9) pulse_tad();
        chk("R3 not done after 10", adif, 1'b0);
        pulse_tad(); chk("R3 done after 11", adif, 1'b1);
        @(negedge clk);
        // R4: start bit cleared, flag set
        rd(2'd0, d); chk("R4 ctrl after done", d, 8'h09);
        // R5: formats with free-running strobe
        auto_en = 1'b1;
        start_conv(10'h3FF, 1'b1, 1'b1); wait_done("R5 right full");
        start_conv(10'h001, 1'b1, 1'b1); wait_done("R5 right one");
        start_conv(10'h155, 1'b0, 1'b1); wait_done("R5 left");
        // R8: writing 1 keeps the flag, 0 clears it
        wr(2'd0, 8'h09); chk("R8 write one", adif, 1'b1);
        wr(2'd0, 8'h05); chk("R8 write zero", adif, 1'b0);
        rd(2'd1, d); chk("R5 reformat hi", d, 8'h01);
        rd(2'd2, d); chk("R5 reformat lo", d, 8'h55);
        wr(2'd0, 8'h01);
        // R6 / R7: abort keeps result and holds off two strobes
        rd(2'd1, h0); rd(2'd2, l0);
        start_conv(10'h123, 1'b0, 1'b0);
        repeat (10) @(negedge clk);
        wr(2'd0, 8'h01);
        rd(2'd0, d); chk("R6 go cleared", d, 8'h01);
        chk("R7 acq low in holdoff", acq, 1'b0);
        wr(2'd0, 8'h03);
        rd(2'd0, d); chk("R7 start ignored in holdoff", d, 8'h01);
        repeat (12) @(negedge clk);
        chk("R7 acq restored", acq, 1'b1);
        chk("R6 no flag", adif, 1'b0);
        rd(2'd1, d); chk("R6 hi kept", d, h0);
        rd(2'd2, d); chk("R6 lo kept", d, l0);
        // R9: hardware trigger
        vin = 10'h0C3; push_exp(10'h0C3, 1'b0);
        @(negedge clk); evt_trig = 1'b1;
        @(negedge clk); evt_trig = 1'b0;
        chk("R9 timer clear", tmr_clr, 1'b1);
        rd(2'd0, d); chk("R9 go set", d, 8'h03);
        wait_done("R9 completes");
        // R10 / R11: sleep on RC clock with interrupt enabled
        sleep_req = 1'b1; clk_is_rc = 1'b1; irq_en = 1'b1;
        start_conv(10'h2F0, 1'b0, 1'b1);
        repeat (60) @(negedge clk);
        chk("R10 no trial before instr", trial_code, 10'h000);
        chk("R10 no done before instr", adif, 1'b0);
        @(negedge clk); instr_stb = 1'b1;
        @(negedge clk); instr_stb = 1'b0;
        wait_done("R10 completes");
        chk("R11 wake pulse", wake_seen, 1'b1);
        // R12: sleep on RC clock, interrupt disabled
        irq_en = 1'b0;
        start_conv(10'h07E, 1'b0, 1'b1);
        @(negedge clk); instr_stb = 1'b1;
        @(negedge clk); instr_stb = 1'b0;
        wait_done("R12 completes");
        chk("R12 no wake", wake_seen, 1'b0);
        chk("R12 shut down", acq, 1'b0);
        rd(2'd0, d); chk("R12 enable kept", d, 8'h09);
        wr(2'd0, 8'h0B);
        rd(2'd0, d); chk("R12 start ignored", d, 8'h09);
        sleep_req = 1'b0; clk_is_rc = 1'b0;
        wr(2'd0, 8'h00); wr(2'd0, 8'h01);
        // R13: sleep on another clock kills the conversion
        rd(2'd1, h0); rd(2'd2, l0);
        start_conv(10'h0F0, 1'b0, 1'b0);
        repeat (12) @(negedge clk);
        sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
        rd(2'd0, d); chk("R13 go cleared enable kept", d, 8'h01);
        chk("R13 shut down", acq, 1'b0);
        repeat (100) @(negedge clk);
        chk("R13 no flag", adif, 1'b0);
        rd(2'd1, d); chk("R13 hi kept", d, h0);
        rd(2'd2, d); chk("R13 lo kept", d, l0);
        chk("R3 scoreboard drained", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule